// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character at a time into a framed bit stream on a single output line. The frame shape is chosen at run time: the character may be five to nine bits wide, an optional parity bit with even or odd sense may follow the data, and one or two stop bits close the frame. The bit period comes from a divisor input, and a double-speed control halves it.

Software-facing logic writes a byte with a strobe. The ninth data bit comes from its own input and is captured together with the byte. A one-deep holding register sits in front of the shift register, so a second character can wait while the first is on the line. That second character then starts with no idle gap. Two flags report progress: one says the holding register can take a character, the other says the last frame has fully left the line. The frame settings are sampled when a character moves from the holding register into the shift register.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the holding-empty flag is 1 and the done flag is 0.
- R2: A frame is sent as a low start bit, then the data bits least significant first, then the parity bit if one is enabled, then the stop bits, which are high. The line is high when idle.
- R3: The character size code sets the data bit count: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8, 111 gives 9, and every other code gives 8.
- R4: In a 9-bit frame the last data bit is the value of the ninth-bit input captured with the write strobe.
- R5: Parity mode 10 appends an even-parity bit, which makes the count of ones over data and parity even. Mode 11 appends an odd-parity bit. Modes 00 and 01 send no parity bit.
- R6: Stop select 0 sends one stop bit and stop select 1 sends two.
- R7: Every bit lasts 16×(divisor+1) clock cycles, or 8×(divisor+1) cycles when double speed is set.
- R8: An accepted write clears the holding-empty flag until the character moves into the shift register. A write made while the holding register is full is ignored.
- R9: The done flag rises when the last stop bit ends and no character is waiting. An accepted write or a clear strobe drops it. A waiting character starts in the cycle right after the previous stop bit, so consecutive start bits are exactly one frame length apart.
- R10: While the enable is low the line stays high, the holding register stays empty and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Bit period divisor |
| dbl_speed | input | 1 | Halve the bit period |
| char_size | input | 3 | Character size code |
| par_mode | input | 2 | Parity mode code |
| two_stop | input | 1 | Send two stop bits |
| tx_en | input | 1 | Transmitter enable |
| wr_stb | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Low eight bits of the character |
| bit9 | input | 1 | Ninth data bit, captured on write |
| clr_done | input | 1 | Clear strobe for the done flag |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Last frame has fully left the line |

## Verification
The bound checker watches several rules on every cycle. When the enable is off, the line returns high and the holding register empties. The line never goes low unless the block was enabled one cycle earlier. An accepted write fills the holding register. A write or a clear strobe drops the done flag. While the done flag is set, the line is high. The frame contents, the parity value, the size decoding, the bit period and the gap between back-to-back frames can only be shown by the bench scenarios. A scoreboard predicts each frame from the settings, samples the line in the middle of every bit, and times the start bits of consecutive frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   // everything the shift stage needs for one frame
   typedef struct packed {
      logic [8:0] data;
      logic [3:0] nbits;
      logic       par_en;
      logic       par_bit;
      logic       stop2;
   } frame_t;

   function automatic logic [3:0] size_to_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 4'd5;
         3'b001:  return 4'd6;
         3'b010:  return 4'd7;
         3'b111:  return 4'd9;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
   parameter int DIV_W    = 12,
   parameter int OVS_NORM = 16,
   parameter int OVS_FAST = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             dbl,
   input  logic [DIV_W-1:0] div,
   output logic             bit_end
);
   localparam int CNT_W = DIV_W + $clog2(OVS_NORM) + 1;

   generate
      if (OVS_FAST < 1 || OVS_FAST > OVS_NORM) begin : g_bad_ovs
         $error("sertx_baud: OVS_FAST must lie in 1..OVS_NORM");
      end
   endgenerate

   logic [CNT_W-1:0] div_p1;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt;

   assign div_p1  = CNT_W'(div) + CNT_W'(1);
   assign period  = dbl ? div_p1 * CNT_W'(OVS_FAST) : div_p1 * CNT_W'(OVS_NORM);
   assign bit_end = run && (cnt == period - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || bit_end)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   input  logic       wr_bit9,
   input  logic       take,
   output logic       full,
   output logic       accept,
   output logic [8:0] data9
);
   assign accept = tx_en && wr_stb && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full  <= 1'b0;
         data9 <= '0;
      end else if (!tx_en) begin
         full <= 1'b0;
      end else if (accept) begin
         full  <= 1'b1;
         data9 <= {wr_bit9, wr_data};
      end else if (take) begin
         full <= 1'b0;
      end
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tx_en,
   input  logic   bit_end,
   input  logic   load,
   input  frame_t ld_frame,
   output logic   txd,
   output logic   busy,
   output logic   avail,
   output logic   frame_end
);
   tx_state_e  state;
   logic [8:0] sh;
   logic [3:0] cnt;
   frame_t     fr_q;

   assign busy      = (state != ST_IDLE);
   assign frame_end = (state == ST_STOP) && bit_end && (cnt == 4'd0);
   assign avail     = (state == ST_IDLE) || frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         txd   <= 1'b1;
         sh    <= '0;
         cnt   <= '0;
         fr_q  <= '0;
      end else if (!tx_en) begin
         state <= ST_IDLE;
         txd   <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (load) begin
                  state <= ST_START;
                  txd   <= 1'b0;
                  fr_q  <= ld_frame;
                  sh    <= ld_frame.data;
               end
            end
            ST_START: begin
               if (bit_end) begin
                  state <= ST_DATA;
                  txd   <= sh[0];
                  sh    <= sh >> 1;
                  cnt   <= fr_q.nbits - 4'd1;
               end
            end
            ST_DATA: begin
               if (bit_end) begin
                  if (cnt != 4'd0) begin
                     txd <= sh[0];
                     sh  <= sh >> 1;
                     cnt <= cnt - 4'd1;
                  end else if (fr_q.par_en) begin
                     state <= ST_PAR;
                     txd   <= fr_q.par_bit;
                  end else begin
                     state <= ST_STOP;
                     txd   <= 1'b1;
                     cnt   <= fr_q.stop2 ? 4'd1 : 4'd0;
                  end
               end
            end
            ST_PAR: begin
               if (bit_end) begin
                  state <= ST_STOP;
                  txd   <= 1'b1;
                  cnt   <= fr_q.stop2 ? 4'd1 : 4'd0;
               end
            end
            ST_STOP: begin
               if (bit_end) begin
                  if (cnt != 4'd0) begin
                     cnt <= cnt - 4'd1;
                  end else if (load) begin
                     state <= ST_START;
                     txd   <= 1'b0;
                     fr_q  <= ld_frame;
                     sh    <= ld_frame.data;
                  end else begin
                     state <= ST_IDLE;
                     txd   <= 1'b1;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
               txd   <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
   import sertx_pkg::*;
#(
   parameter int DIV_W    = 12,
   parameter int OVS_NORM = 16,
   parameter int OVS_FAST = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             dbl_speed,
   input  logic [2:0]       char_size,
   input  logic [1:0]       par_mode,
   input  logic             two_stop,
   input  logic             tx_en,
   input  logic             wr_stb,
   input  logic [7:0]       wr_data,
   input  logic             bit9,
   input  logic             clr_done,
   output logic             txd,
   output logic             hold_empty,
   output logic             tx_done
);
   localparam int CHAR_MAX = 9;

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("sertx_top: DIV_W must lie in 1..16");
      end
   endgenerate

   logic             hold_full;
   logic             accept;
   logic [8:0]       hold_data;
   logic             load;
   logic             busy;
   logic             avail;
   logic             frame_end;
   logic             bit_end;
   logic [3:0]       nbits;
   logic [CHAR_MAX-1:0] keep_mask;
   frame_t           next_frame;

   assign nbits = size_to_bits(char_size);

   // one mask bit per data position that belongs to the character
   genvar gi;
   generate
      for (gi = 0; gi < CHAR_MAX; gi++) begin : g_mask
         assign keep_mask[gi] = (4'(gi) < nbits);
      end
   endgenerate

   always_comb begin
      next_frame.data    = hold_data & keep_mask;
      next_frame.nbits   = nbits;
      next_frame.par_en  = par_mode[1];
      next_frame.par_bit = (^(hold_data & keep_mask)) ^ par_mode[0];
      next_frame.stop2   = two_stop;
   end

   assign load       = avail && hold_full && tx_en;
   assign hold_empty = !hold_full;

   sertx_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .wr_bit9 (bit9),
      .take    (load),
      .full    (hold_full),
      .accept  (accept),
      .data9   (hold_data)
   );

   sertx_baud #(
      .DIV_W    (DIV_W),
      .OVS_NORM (OVS_NORM),
      .OVS_FAST (OVS_FAST)
   ) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .dbl     (dbl_speed),
      .div     (baud_div),
      .bit_end (bit_end)
   );

   sertx_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .bit_end   (bit_end),
      .load      (load),
      .ld_frame  (next_frame),
      .txd       (txd),
      .busy      (busy),
      .avail     (avail),
      .frame_end (frame_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_done <= 1'b0;
      else if (clr_done || accept)
         tx_done <= 1'b0;
      else if (frame_end && !load)
         tx_done <= 1'b1;
   end

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_stb,
   input logic clr_done,
   input logic txd,
   input logic hold_empty,
   input logic tx_done
);
   // R10: disabling forces the line high on the next cycle
   a_r10_line_high_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> txd);

   // R10: disabling empties the holding register
   a_r10_hold_empty_off: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> hold_empty);

   // R10: the line only goes low if the block was enabled one cycle earlier
   a_r10_low_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> $past(tx_en));

   // R8: an accepted write fills the holding register
   a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && wr_stb && hold_empty) |=> !hold_empty);

   // R9: a write or a clear strobe drops the done flag
   a_r9_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done || (tx_en && wr_stb && hold_empty)) |=> !tx_done);

   // R9: while done is set, the line is idle
   a_r9_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> txd);

endmodule

bind sertx_top sertx_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .wr_stb     (wr_stb),
   .clr_done   (clr_done),
   .txd        (txd),
   .hold_empty (hold_empty),
   .tx_done    (tx_done)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] baud_div = '0;
   logic             dbl_speed = 1'b0;
   logic [2:0]       char_size = 3'b011;
   logic [1:0]       par_mode = 2'b00;
   logic             two_stop = 1'b0;
   logic             tx_en = 1'b0;
   logic             wr_stb = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             bit9 = 1'b0;
   logic             clr_done = 1'b0;
   logic             txd;
   logic             hold_empty;
   logic             tx_done;

   always #4 clk = ~clk;

   sertx_top #(.DIV_W(DIV_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_div   (baud_div),
      .dbl_speed  (dbl_speed),
      .char_size  (char_size),
      .par_mode   (par_mode),
      .two_stop   (two_stop),
      .tx_en      (tx_en),
      .wr_stb     (wr_stb),
      .wr_data    (wr_data),
      .bit9       (bit9),
      .clr_done   (clr_done),
      .txd        (txd),
      .hold_empty (hold_empty),
      .tx_done    (tx_done)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done_run = 0;

   logic [12:0] q_bits[$];
   int          q_len[$];
   string       q_tag[$];
   int          start_cyc[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_run) begin
         done_run = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // R3: size code to bit count
   function automatic int size_bits(input logic [2:0] code);
      case (code)
         3'b000:  return 5;
         3'b001:  return 6;
         3'b010:  return 7;
         3'b111:  return 9;
         default: return 8;
      endcase
   endfunction

   // R7: bit period
   function automatic int bit_period();
      return (int'(baud_div) + 1) * (dbl_speed ? 8 : 16);
   endfunction

   // driver: predicts the frame and pushes it, then strobes the write
   task automatic send(input logic [7:0] d, input logic b9, input bit expect_ok, input string tag);
      logic [12:0] fb;
      int          n;
      int          len;
      int          ones;
      logic [8:0]  d9;
      if (expect_ok) begin
         d9   = {b9, d};
         n    = size_bits(char_size);
         fb   = '0;
         len  = 0;
         ones = 0;
         fb[len] = 1'b0;  len++;                      // R2 start
         for (int i = 0; i < n; i++) begin            // R2 LSB first, R4 ninth bit
            fb[len] = d9[i];
            ones += int'(d9[i]);
            len++;
         end
         if (par_mode == 2'b10) begin fb[len] = ones[0];  len++; end   // R5 even
         if (par_mode == 2'b11) begin fb[len] = ~ones[0]; len++; end   // R5 odd
         fb[len] = 1'b1; len++;                                     // R6 stop
         if (two_stop) begin fb[len] = 1'b1; len++; end
         q_bits.push_back(fb);
         q_len.push_back(len);
         q_tag.push_back(tag);
      end
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_data = d;
      bit9    = b9;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic wait_done();
      wait (q_len.size() == 0 && tx_done == 1'b1);
      @(negedge clk);
   endtask

   // monitor: pops the predicted frame and samples the middle of every bit
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && txd === 1'b0) begin
            start_cyc.push_back(cyc);
            if (q_len.size() == 0) begin
               chk(1'b0, "R2 unexpected frame", 1, 0);
               wait (txd === 1'b1);
            end else begin
               logic [12:0] fb;
               int          len;
               int          p;
               string       tag;
               fb  = q_bits.pop_front();
               len = q_len.pop_front();
               tag = q_tag.pop_front();
               p   = bit_period();
               repeat (p / 2) @(negedge clk);
               for (int i = 0; i < len; i++) begin
                  chk(txd === fb[i], $sformatf("%s bit%0d", tag, i), int'(txd), int'(fb[i]));
                  if (i < len - 1) repeat (p) @(negedge clk);
               end
               repeat (p / 2 - 1) @(negedge clk);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int gap;
      int b;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1,        "R1 line during reset", int'(txd), 1);
      chk(hold_empty === 1'b1, "R1 hold_empty during reset", int'(hold_empty), 1);
      chk(tx_done === 1'b0,    "R1 done during reset", int'(tx_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd === 1'b1, "R1 line after reset", int'(txd), 1);
      tx_en = 1'b1;
      @(negedge clk);

      // R2 8N1, divisor 0
      send(8'hA5, 1'b0, 1, "R2 8N1");
      wait_done();
      chk(tx_done === 1'b1,    "R9 done after frame", int'(tx_done), 1);
      chk(hold_empty === 1'b1, "R8 empty after frame", int'(hold_empty), 1);

      // R9 clear strobe
      clr_done = 1'b1;
      @(negedge clk);
      clr_done = 1'b0;
      chk(tx_done === 1'b0, "R9 clear strobe", int'(tx_done), 0);

      // R3 R5 sizes with parity
      char_size = 3'b000; par_mode = 2'b10;
      send(8'h13, 1'b0, 1, "R3 R5 5E1");
      wait_done();
      char_size = 3'b001; par_mode = 2'b11;
      send(8'h2C, 1'b0, 1, "R3 R5 6O1");
      wait_done();
      char_size = 3'b010; par_mode = 2'b10;
      send(8'h7F, 1'b0, 1, "R3 R5 7E1");
      wait_done();
      char_size = 3'b100; par_mode = 2'b00;
      send(8'h81, 1'b0, 1, "R3 code100 is 8 bits");
      wait_done();

      // R4 R6 nine bits, two stops
      char_size = 3'b111; par_mode = 2'b11; two_stop = 1'b1;
      send(8'h0F, 1'b1, 1, "R4 R6 9O2 b9=1");
      wait_done();
      par_mode = 2'b10;
      send(8'hF0, 1'b0, 1, "R4 R6 9E2 b9=0");
      wait_done();

      // R5 reserved code sends no parity
      char_size = 3'b011; par_mode = 2'b01; two_stop = 1'b0;
      send(8'h01, 1'b0, 1, "R5 reserved parity");
      wait_done();

      // R7 R8 R9 normal speed, divisor 1, back to back, third write ignored
      par_mode = 2'b00; baud_div = 8'd1; dbl_speed = 1'b0;
      start_cyc.delete();
      send(8'h3C, 1'b0, 1, "R8 first");
      send(8'hC3, 1'b0, 1, "R8 second");
      chk(hold_empty === 1'b0, "R8 full after second write", int'(hold_empty), 0);
      send(8'hFF, 1'b0, 0, "R8 ignored");
      chk(hold_empty === 1'b0, "R8 still full after ignored write", int'(hold_empty), 0);
      wait_done();
      b = start_cyc.size();
      chk(b == 2, "R8 frame count", b, 2);
      if (b >= 2) begin
         gap = start_cyc[1] - start_cyc[0];
         chk(gap == 10 * 32, "R7 R9 gap at normal speed", gap, 10 * 32);
      end

      // R7 R9 double speed, divisor 2, two stop bits
      dbl_speed = 1'b1; baud_div = 8'd2; two_stop = 1'b1; par_mode = 2'b10;
      start_cyc.delete();
      send(8'h5A, 1'b0, 1, "R7 dbl first");
      send(8'h00, 1'b0, 1, "R7 dbl second");
      wait_done();
      b = start_cyc.size();
      chk(b == 2, "R7 frame count dbl", b, 2);
      if (b >= 2) begin
         gap = start_cyc[1] - start_cyc[0];
         chk(gap == 12 * 24, "R7 R9 gap at double speed", gap, 12 * 24);
      end

      // R10 disabled: writes ignored, line high
      tx_en = 1'b0;
      @(negedge clk);
      send(8'h55, 1'b0, 0, "R10 write while off");
      chk(hold_empty === 1'b1, "R10 hold stays empty", int'(hold_empty), 1);
      b = 0;
      repeat (100) begin
         @(negedge clk);
         if (txd !== 1'b1) b++;
      end
      chk(b == 0, "R10 line low cycles while off", b, 0);
      tx_en = 1'b1;
      b = 0;
      repeat (100) begin
         @(negedge clk);
         if (txd !== 1'b1 || hold_empty !== 1'b1) b++;
      end
      chk(b == 0, "R10 no frame after re-enable", b, 0);

      finish_run();
   end

endmodule